// File: doc/BRIEF.md
# Ring-Buffer Memory Address Generator

This block forms the byte address for each memory access of an audio signal processor. The processor runs a fixed microprogram once per audio sample. Its delay lines live in a circular region of external memory. On every access step the block takes a word offset from the instruction's offset slot. It can add a dynamic address register and a unit increment. It then applies one of two modes. Ring mode adds a per-sample rotating base counter and wraps the result to the ring length. Table mode uses the plain sum, limited to 16 bits. The resulting word index is doubled and added to the ring base, which gives a byte address.

The block owns three pieces of state: the rotating counter, the ring-length mask and the ring base. All three change only on the sample-boundary strobe. The counter steps down by one on each strobe and refills from the mask when it reaches zero. The mask and the base are taken from their inputs on the same strobe, so they stay fixed for a whole sample. Addresses are computed only on odd steps. The result is registered, so it is ready on the following step, when the memory operation takes place.

Top module: `ringbuf_agen`

## Requirements
- R1: When `step_par_i` is 1 in a cycle, `addr_vld_o` is 1 in the next cycle. When `step_par_i` is 0, `addr_vld_o` is 0 in the next cycle and `addr_o` keeps its previous value.
- R2: The word sum is `ofs_i`, plus `dyn_addr_i` (zero-extended) when `dyn_en_i` is 1, plus 1 when `inc_en_i` is 1.
- R3: When `tbl_en_i` is 0, the rotating counter is added to the word sum, and the result is ANDed with the ring-length mask register.
- R4: When `tbl_en_i` is 1, the counter is not added and the word sum is truncated to its low 16 bits.
- R5: `addr_o` equals the ring base register plus twice the masked word, modulo 2^23, so an overflow wraps without notice.
- R6: After reset, `addr_o` is 0, `addr_vld_o` is 0, the mask register is 0x1FFF, the base register is 0 and the counter is 1. The mask and base inputs have no effect until the first strobe.
- R7: Each `sample_end_i` pulse lowers the counter by one. If the result is zero, the counter instead loads the mask register value that was in effect before the pulse.
- R8: On `sample_end_i`, the mask register loads `ring_mask_i` and the base register loads `ring_base_i`. An address computed in the same cycle as the pulse uses the counter, mask and base from before the pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| step_par_i | input | 1 | Parity of the current microprogram step (1 = odd, address step) |
| sample_end_i | input | 1 | One-cycle strobe marking the end of a sample |
| tbl_en_i | input | 1 | Table mode: bypass the counter, limit to 16 bits |
| dyn_en_i | input | 1 | Add the dynamic address register |
| inc_en_i | input | 1 | Add one to the word sum |
| ofs_i | input | 16 | Word offset from the selected offset slot |
| dyn_addr_i | input | 12 | Dynamic address register value |
| ring_mask_i | input | 16 | Ring-length mask, taken on the strobe |
| ring_base_i | input | 23 | Ring base byte address, taken on the strobe |
| addr_o | output | 23 | Registered byte address |
| addr_vld_o | output | 1 | Registered flag: `addr_o` was produced this step |

## Verification
The address computation and the end-of-sample update of the counter, mask and base can fall in the same cycle. The bench provokes this by raising the strobe together with an odd step, at a time when the pulse both changes the counter and loads a new mask and base. The resulting address must still reflect the old counter, old mask and old base. The next odd step must then reflect the new values. One such case places the new base near the top of the address space, so the wrap also shows. A long countdown carries the counter down to one and through the reload, and a random phase then mixes strobes with odd steps in both modes.

// File: rtl/ringagen_pkg.sv
`timescale 1ns/1ps
package ringagen_pkg;
  // per-access control bits taken from the instruction
  typedef struct packed {
    logic tbl;     // table mode
    logic dyn_en;  // add dynamic address
    logic inc_en;  // add one
  } agen_ctl_t;

  // build an all-ones mask of n bits inside a w-bit word
  function automatic logic [31:0] ones_mask(input int n);
    logic [31:0] m;
    m = '0;
    for (int i = 0; i < 32; i++) begin
      if (i < n) m[i] = 1'b1;
    end
    return m;
  endfunction
endpackage

// File: rtl/ringagen_state.sv
`timescale 1ns/1ps
module ringagen_state #(
  parameter int WORD_W   = 16,
  parameter int ADDR_W   = 23,
  parameter int MASK_RST = 'h1FFF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sample_end,
  input  logic [WORD_W-1:0] mask_in,
  input  logic [ADDR_W-1:0] base_in,
  output logic [WORD_W-1:0] ctr,
  output logic [WORD_W-1:0] mask,
  output logic [ADDR_W-1:0] base
);
  localparam logic [WORD_W-1:0] CTR_RST = WORD_W'(1);
  localparam logic [WORD_W-1:0] MSK_RST = WORD_W'(MASK_RST);

  logic [WORD_W-1:0] ctr_q, mask_q, ctr_dec;
  logic [ADDR_W-1:0] base_q;

  assign ctr_dec = ctr_q - CTR_RST;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctr_q  <= CTR_RST;
      mask_q <= MSK_RST;
      base_q <= '0;
    end else if (sample_end) begin
      // refill uses the mask that governed the ending sample
      ctr_q  <= (ctr_dec == '0) ? mask_q : ctr_dec;
      mask_q <= mask_in;
      base_q <= base_in;
    end
  end

  assign ctr  = ctr_q;
  assign mask = mask_q;
  assign base = base_q;
endmodule

// File: rtl/ringagen_sum.sv
`timescale 1ns/1ps
module ringagen_sum
  import ringagen_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int DYN_W  = 12,
  parameter int TBL_W  = 16,
  parameter int ADDR_W = 23
) (
  input  agen_ctl_t         ctl,
  input  logic [WORD_W-1:0] ofs,
  input  logic [DYN_W-1:0]  dyn,
  input  logic [WORD_W-1:0] ctr,
  input  logic [WORD_W-1:0] mask,
  input  logic [ADDR_W-1:0] base,
  output logic [ADDR_W-1:0] byte_addr
);
  localparam int PAD_W = ADDR_W - WORD_W - 1;

  logic [WORD_W-1:0] tbl_mask, dyn_term, inc_term, ctr_term, sum, word;

  generate
    if (TBL_W >= WORD_W) begin : g_tbl_full
      assign tbl_mask = '1;
    end else begin : g_tbl_part
      localparam logic [31:0] TM = ones_mask(TBL_W);
      assign tbl_mask = TM[WORD_W-1:0];
    end
  endgenerate

  always_comb begin
    dyn_term = ctl.dyn_en ? {{(WORD_W-DYN_W){1'b0}}, dyn} : '0;
    inc_term = {{(WORD_W-1){1'b0}}, ctl.inc_en};
    ctr_term = ctl.tbl ? '0 : ctr;
    sum      = ofs + dyn_term + inc_term + ctr_term;
    word     = sum & (ctl.tbl ? tbl_mask : mask);
    byte_addr = base + {{PAD_W{1'b0}}, word, 1'b0};
  end
endmodule

// File: rtl/ringbuf_agen.sv
`timescale 1ns/1ps
module ringbuf_agen
  import ringagen_pkg::*;
#(
  parameter int WORD_W   = 16,
  parameter int DYN_W    = 12,
  parameter int TBL_W    = 16,
  parameter int ADDR_W   = 23,
  parameter int MASK_RST = 'h1FFF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              step_par_i,
  input  logic              sample_end_i,
  input  logic              tbl_en_i,
  input  logic              dyn_en_i,
  input  logic              inc_en_i,
  input  logic [WORD_W-1:0] ofs_i,
  input  logic [DYN_W-1:0]  dyn_addr_i,
  input  logic [WORD_W-1:0] ring_mask_i,
  input  logic [ADDR_W-1:0] ring_base_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              addr_vld_o
);
  agen_ctl_t         ctl;
  logic [WORD_W-1:0] ctr_w, mask_w;
  logic [ADDR_W-1:0] base_w, byte_w;
  logic [ADDR_W-1:0] addr_q;
  logic              vld_q;

  assign ctl = '{tbl: tbl_en_i, dyn_en: dyn_en_i, inc_en: inc_en_i};

  ringagen_state #(.WORD_W(WORD_W), .ADDR_W(ADDR_W), .MASK_RST(MASK_RST)) u_state (
    .clk(clk), .rst(rst), .sample_end(sample_end_i),
    .mask_in(ring_mask_i), .base_in(ring_base_i),
    .ctr(ctr_w), .mask(mask_w), .base(base_w)
  );

  ringagen_sum #(.WORD_W(WORD_W), .DYN_W(DYN_W), .TBL_W(TBL_W), .ADDR_W(ADDR_W)) u_sum (
    .ctl(ctl), .ofs(ofs_i), .dyn(dyn_addr_i), .ctr(ctr_w),
    .mask(mask_w), .base(base_w), .byte_addr(byte_w)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q <= '0;
      vld_q  <= 1'b0;
    end else begin
      vld_q <= step_par_i;
      if (step_par_i) addr_q <= byte_w;
    end
  end

  assign addr_o     = addr_q;
  assign addr_vld_o = vld_q;
endmodule

// File: rtl/ringagen_chk.sv
`timescale 1ns/1ps
module ringagen_chk #(
  parameter int WORD_W = 16,
  parameter int ADDR_W = 23
) (
  input logic              clk,
  input logic              rst,
  input logic              step_par,
  input logic              sample_end,
  input logic              addr_vld,
  input logic [ADDR_W-1:0] addr,
  input logic [WORD_W-1:0] ctr,
  input logic [WORD_W-1:0] mask
);
  assert_vld_odd_R1: assert property (@(posedge clk) disable iff (rst)
    step_par |=> addr_vld);

  assert_hold_even_R1: assert property (@(posedge clk) disable iff (rst)
    !step_par |=> (!addr_vld && $stable(addr)));

  assert_ctr_reset_R6: assert property (@(posedge clk)
    rst |=> (ctr == WORD_W'(1)));

  assert_ctr_dec_R7: assert property (@(posedge clk) disable iff (rst)
    (sample_end && ctr != WORD_W'(1)) |=> (ctr == WORD_W'($past(ctr) - WORD_W'(1))));

  assert_ctr_reload_R7: assert property (@(posedge clk) disable iff (rst)
    (sample_end && ctr == WORD_W'(1)) |=> (ctr == $past(mask)));

  assert_ctr_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !sample_end |=> $stable(ctr) && $stable(mask));
endmodule

bind ringbuf_agen ringagen_chk #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .step_par(step_par_i), .sample_end(sample_end_i),
  .addr_vld(addr_vld_o), .addr(addr_o), .ctr(ctr_w), .mask(mask_w)
);

// File: tb/sim_ringbuf_agen.sv
`timescale 1ns/1ps
module sim_ringbuf_agen;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst, step_par, sample_end, tbl_en, dyn_en, inc_en;
  logic [15:0] ofs, ring_mask;
  logic [11:0] dyn_addr;
  logic [22:0] ring_base, addr;
  logic        addr_vld;

  ringbuf_agen u0 (
    .clk(clk), .rst(rst), .step_par_i(step_par), .sample_end_i(sample_end),
    .tbl_en_i(tbl_en), .dyn_en_i(dyn_en), .inc_en_i(inc_en), .ofs_i(ofs),
    .dyn_addr_i(dyn_addr), .ring_mask_i(ring_mask), .ring_base_i(ring_base),
    .addr_o(addr), .addr_vld_o(addr_vld)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  // reference state
  int unsigned m_ctr = 1, m_mask = 'h1FFF, m_base = 0;
  logic [22:0] e_addr = '0;
  logic        e_vld  = 1'b0;

  task automatic compare(input string tag);
    n_chk++;
    if (addr !== e_addr || addr_vld !== e_vld) begin
      n_fail++;
      $display("FAIL %s: addr=%h vld=%b expected addr=%h vld=%b", tag, addr, addr_vld, e_addr, e_vld);
    end
  endtask

  task automatic cyc(input bit st, input bit se, input bit tb, input bit dy_en, input bit in_en,
                     input logic [15:0] o, input logic [11:0] dy,
                     input logic [15:0] rm, input logic [22:0] rb, input string tag);
    int unsigned s, w;
    step_par = st; sample_end = se; tbl_en = tb; dyn_en = dy_en; inc_en = in_en;
    ofs = o; dyn_addr = dy; ring_mask = rm; ring_base = rb;
    if (st) begin
      s = o + (dy_en ? dy : 0) + (in_en ? 1 : 0) + (tb ? 0 : m_ctr);
      w = tb ? (s & 'hFFFF) : (s & m_mask);
      e_addr = 23'((m_base + 2 * w) & 'h7FFFFF);
      e_vld  = 1'b1;
    end else begin
      e_vld = 1'b0;
    end
    if (se) begin
      m_ctr = (m_ctr - 1) & 'hFFFF;
      if (m_ctr == 0) m_ctr = m_mask;
      m_mask = rm;
      m_base = rb;
    end
    @(posedge clk); #1;
    compare(tag);
  endtask

  initial begin
    #1_500_000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: run did not finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; step_par = 0; sample_end = 0; tbl_en = 0; dyn_en = 0; inc_en = 0;
    ofs = '0; dyn_addr = '0; ring_mask = '0; ring_base = '0;
    repeat (3) @(posedge clk);
    #1;
    compare("R6 reset outputs");
    rst = 1'b0;
    // R6: reset mask/base/counter, inputs not yet taken
    cyc(1, 0, 0, 0, 0, 16'h0000, 12'h000, 16'h00F0, 23'h000100, "R6");
    // R1: even step holds address, drops valid
    cyc(0, 0, 0, 0, 0, 16'h1234, 12'h000, 16'h00F0, 23'h000100, "R1");
    // R2: offset + dyn + 1 in table mode
    cyc(1, 0, 1, 1, 1, 16'h0100, 12'h020, 16'h00F0, 23'h000100, "R2");
    // R4: table mode truncates to 16 bits
    cyc(1, 0, 1, 1, 1, 16'hFFFF, 12'hFFF, 16'h00F0, 23'h000100, "R4");
    // R3: ring mode adds counter and wraps on the mask
    cyc(1, 0, 0, 0, 1, 16'h1FFF, 12'h000, 16'h00F0, 23'h000100, "R3");
    // R8: strobe with an odd step uses the old state
    cyc(1, 1, 0, 0, 0, 16'h0010, 12'h000, 16'h00FF, 23'h7FFF00, "R8");
    // R5: new base near the top, byte address wraps
    cyc(1, 0, 0, 0, 0, 16'h0000, 12'h000, 16'h00FF, 23'h7FFF00, "R5");
    // R7: count the counter down to one
    for (int i = 0; i < 'h1FFE; i++)
      cyc(0, 1, 0, 0, 0, 16'h0000, 12'h000, 16'h00FF, 23'h7FFF00, "R7 countdown");
    cyc(1, 0, 0, 0, 0, 16'h0000, 12'h000, 16'h00FF, 23'h7FFF00, "R7 counter at one");
    cyc(0, 1, 0, 0, 0, 16'h0000, 12'h000, 16'h00FF, 23'h7FFF00, "R7 reload strobe");
    cyc(1, 0, 0, 0, 0, 16'h0000, 12'h000, 16'h00FF, 23'h7FFF00, "R7 after reload");
    // mixed random traffic
    for (int i = 0; i < 4000; i++) begin
      bit tb;
      tb = $urandom_range(0, 1);
      cyc($urandom_range(0, 1), ($urandom_range(0, 3) == 0), tb,
          $urandom_range(0, 1), $urandom_range(0, 1),
          16'($urandom), 12'($urandom), 16'($urandom_range(1, 63)),
          23'($urandom), tb ? "R4 random" : "R3 random");
    end
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule